// File: doc/BRIEF.md
# Coprocessor Operand Transfer Sequencer

This block is the bus-side sequencer of a numeric coprocessor that shadows its host's bus cycles. When the host runs an operand cycle, the sequencer records the full address. On a load, the host's own cycle delivers the first word. If the operand is longer than a word, the sequencer asks the host for the bus with a request pulse, waits for the grant pulse, reads the remaining bytes one per clock at rising addresses, and then hands the bus back with a second pulse.

A store works differently. The host's write cycle carries no useful data, so the sequencer keeps only its starting address. It holds until the execution side signals that the result is ready. It then takes the bus and writes every byte of the operand. The busy output is high for the whole operation, and a completed load is presented on a wide operand output for one cycle.

Top module: `opx_seq`

## Requirements
- R1: When `host_cyc` is high while the block is idle, the address on `host_addr` is latched, and `busy` is high from the next cycle until the operation finishes. It is low again when the block is idle.
- R2: A load with `len_code` 0 (2 bytes) takes the operand from `host_data` (bits 7:0 are the byte at the captured address). It raises no request pulse and no bus strobe.
- R3: Length codes map to operand sizes of 0 = 2 bytes, 1 = 4 bytes, 2 = 8 bytes and 3 = 10 bytes. For a longer load, the sequencer reads bytes 2 onward itself with `bus_rd`, one byte per cycle. The addresses run upward from the captured address + 2.
- R4: A bus request is a single-cycle pulse on `rq_o`. No `bus_rd` or `bus_wr` strobe appears until a grant pulse on `gt_i` has been received.
- R5: The bus is kept until the last byte of the operand has moved. Exactly one single-cycle release pulse on `rq_o` then follows, one release per takeover.
- R6: A store (`host_wr` high) is a dummy cycle. The sequencer raises no request until `result_rdy` is seen. It then takes the bus and writes all bytes from the captured address upward, with byte i taken from `res_data[8i+7:8i]`. A one-word store also takes the bus.
- R7: A finished load pulses `op_valid` for one cycle. On `op_data`, byte i sits at bits 8i+7:8i and bytes beyond the operand length read zero. `busy` is low in the following cycle.
- R8: `host_cyc` pulses that arrive while `busy` is high are ignored. They change neither the addresses used nor the operand delivered.
- R9: After reset the block is idle, with `busy`, `rq_o`, `bus_rd`, `bus_wr` and `op_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cyc | input | 1 | Host operand cycle strobe |
| host_wr | input | 1 | Host cycle is a store (dummy cycle) |
| host_addr | input | 20 | Address of the host operand cycle |
| host_data | input | 16 | Data word of the host load cycle |
| len_code | input | 2 | Operand length code |
| result_rdy | input | 1 | Store result available |
| res_data | input | 80 | Store operand, byte i at bits 8i+7:8i |
| gt_i | input | 1 | Grant pulse from the host |
| rq_o | output | 1 | Request and release pulses |
| bus_addr | output | 20 | Address of the sequencer's own transfer |
| bus_din | input | 8 | Read byte from memory |
| bus_dout | output | 8 | Write byte to memory |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| busy | output | 1 | Operation in progress |
| op_valid | output | 1 | Load operand complete (one cycle) |
| op_data | output | 80 | Assembled load operand |

## Verification
Loads are run with all four length codes. The 2-byte case separates the no-takeover path from the others, and the 10-byte case confirms the bus is held across every byte. Stores with each length show that the dummy cycle only records the address, that nothing is requested before the result is ready, and that even a one-word store takes the bus. A memory model compares every byte and checks a sentinel just past each stored operand. Stray host cycles injected during a long load and during a pending store separate a design that ignores them from one that re-captures.

// File: rtl/opx_pkg.sv
package opx_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_HOLD,
      S_REQ,
      S_WGT,
      S_XFER,
      S_REL,
      S_FIN
   } opx_state_e;

   // operand size in bytes for each length code
   function automatic int unsigned opx_len_bytes(input logic [1:0] code,
                                                 input int unsigned host_b,
                                                 input int unsigned max_b);
      case (code)
         2'd0:    return host_b;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return max_b;
      endcase
   endfunction
endpackage

// File: rtl/opx_addr_unit.sv
module opx_addr_unit #(
   parameter int ADDR_W = 20,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_ld,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              idx_ld,
   input  logic [IDX_W-1:0]  idx_init,
   input  logic              idx_inc,
   output logic [IDX_W-1:0]  idx_o,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] base_q;
   logic [IDX_W-1:0]  idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         idx_q  <= '0;
      end else begin
         if (base_ld) base_q <= base_i;
         if (idx_ld)       idx_q <= idx_init;
         else if (idx_inc) idx_q <= idx_q + 1'b1;
      end
   end

   assign idx_o  = idx_q;
   assign addr_o = base_q + ADDR_W'(idx_q);
endmodule

// File: rtl/opx_byte_buf.sv
module opx_byte_buf #(
   parameter int BYTE_W     = 8,
   parameter int NBYTES     = 10,
   parameter int HOST_BYTES = 2,
   parameter int IDX_W      = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         host_ld,
   input  logic [HOST_BYTES*BYTE_W-1:0] host_data,
   input  logic                         res_ld,
   input  logic [NBYTES*BYTE_W-1:0]     res_data,
   input  logic                         rd_we,
   input  logic [IDX_W-1:0]             idx,
   input  logic [BYTE_W-1:0]            rd_byte,
   output logic [BYTE_W-1:0]            sel_byte,
   output logic [NBYTES*BYTE_W-1:0]     flat_o
);
   logic [BYTE_W-1:0] b_q [NBYTES];

   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      logic [BYTE_W-1:0] host_v;
      if (i < HOST_BYTES) begin : g_host
         assign host_v = host_data[i*BYTE_W +: BYTE_W];
      end else begin : g_zero
         assign host_v = '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              b_q[i] <= '0;
         else if (host_ld)                        b_q[i] <= host_v;
         else if (res_ld)                         b_q[i] <= res_data[i*BYTE_W +: BYTE_W];
         else if (rd_we && idx == IDX_W'(i))      b_q[i] <= rd_byte;
      end

      assign flat_o[i*BYTE_W +: BYTE_W] = b_q[i];
   end

   always_comb begin
      sel_byte = '0;
      for (int k = 0; k < NBYTES; k++)
         if (idx == IDX_W'(k)) sel_byte = b_q[k];
   end
endmodule

// File: rtl/opx_ctrl.sv
module opx_ctrl
   import opx_pkg::*;
#(
   parameter int HOST_BYTES = 2,
   parameter int MAX_BYTES  = 10,
   parameter int IDX_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_cyc,
   input  logic             host_wr,
   input  logic [1:0]       len_code,
   input  logic             result_rdy,
   input  logic             gt_i,
   input  logic [IDX_W-1:0] idx,
   output logic             base_ld,
   output logic             idx_ld,
   output logic [IDX_W-1:0] idx_init,
   output logic             idx_inc,
   output logic             host_ld,
   output logic             res_ld,
   output logic             rd_we,
   output logic             rq_o,
   output logic             bus_rd,
   output logic             bus_wr,
   output logic             busy,
   output logic             op_valid
);
   opx_state_e       st_q, st_d;
   logic             wr_q;
   logic [IDX_W-1:0] last_q;
   logic [IDX_W-1:0] len_now;

   assign len_now = IDX_W'(opx_len_bytes(len_code, HOST_BYTES, MAX_BYTES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         wr_q   <= 1'b0;
         last_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == S_IDLE && host_cyc) begin
            wr_q   <= host_wr;
            last_q <= len_now - 1'b1;
         end
      end
   end

   always_comb begin
      st_d     = st_q;
      base_ld  = 1'b0;
      idx_ld   = 1'b0;
      idx_init = '0;
      idx_inc  = 1'b0;
      host_ld  = 1'b0;
      res_ld   = 1'b0;
      rq_o     = 1'b0;
      bus_rd   = 1'b0;
      bus_wr   = 1'b0;
      rd_we    = 1'b0;
      op_valid = 1'b0;
      case (st_q)
         S_IDLE: if (host_cyc) begin
            base_ld = 1'b1;
            if (host_wr) begin
               st_d = S_HOLD;
            end else begin
               host_ld  = 1'b1;
               idx_ld   = 1'b1;
               idx_init = IDX_W'(HOST_BYTES);
               st_d     = (len_now == IDX_W'(HOST_BYTES)) ? S_FIN : S_REQ;
            end
         end
         S_HOLD: if (result_rdy) begin
            res_ld   = 1'b1;
            idx_ld   = 1'b1;
            idx_init = '0;
            st_d     = S_REQ;
         end
         S_REQ: begin
            rq_o = 1'b1;
            st_d = S_WGT;
         end
         S_WGT: if (gt_i) st_d = S_XFER;
         S_XFER: begin
            bus_rd = !wr_q;
            bus_wr = wr_q;
            rd_we  = !wr_q;
            if (idx == last_q) st_d = S_REL;
            else               idx_inc = 1'b1;
         end
         S_REL: begin
            rq_o = 1'b1;
            st_d = S_FIN;
         end
         S_FIN: begin
            op_valid = !wr_q;
            st_d     = S_IDLE;
         end
         default: st_d = S_IDLE;
      endcase
   end

   assign busy = (st_q != S_IDLE);
endmodule

// File: rtl/opx_seq.sv
module opx_seq #(
   parameter int ADDR_W     = 20,
   parameter int BYTE_W     = 8,
   parameter int HOST_BYTES = 2,
   parameter int MAX_BYTES  = 10
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         host_cyc,
   input  logic                         host_wr,
   input  logic [ADDR_W-1:0]            host_addr,
   input  logic [HOST_BYTES*BYTE_W-1:0] host_data,
   input  logic [1:0]                   len_code,
   input  logic                         result_rdy,
   input  logic [MAX_BYTES*BYTE_W-1:0]  res_data,
   input  logic                         gt_i,
   output logic                         rq_o,
   output logic [ADDR_W-1:0]            bus_addr,
   input  logic [BYTE_W-1:0]            bus_din,
   output logic [BYTE_W-1:0]            bus_dout,
   output logic                         bus_rd,
   output logic                         bus_wr,
   output logic                         busy,
   output logic                         op_valid,
   output logic [MAX_BYTES*BYTE_W-1:0]  op_data
);
   localparam int IDX_W = $clog2(MAX_BYTES + 1);

   if (HOST_BYTES < 1 || HOST_BYTES >= 4) begin : g_bad_host
      $error("opx_seq: HOST_BYTES must be 1..3");
   end
   if (MAX_BYTES < 8) begin : g_bad_max
      $error("opx_seq: MAX_BYTES must be at least 8");
   end

   logic             base_ld, idx_ld, idx_inc, host_ld, res_ld, rd_we;
   logic [IDX_W-1:0] idx_init, idx;

   opx_ctrl #(.HOST_BYTES(HOST_BYTES), .MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .host_cyc(host_cyc), .host_wr(host_wr),
      .len_code(len_code), .result_rdy(result_rdy), .gt_i(gt_i), .idx(idx),
      .base_ld(base_ld), .idx_ld(idx_ld), .idx_init(idx_init), .idx_inc(idx_inc),
      .host_ld(host_ld), .res_ld(res_ld), .rd_we(rd_we), .rq_o(rq_o),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .busy(busy), .op_valid(op_valid)
   );

   opx_addr_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .base_ld(base_ld), .base_i(host_addr),
      .idx_ld(idx_ld), .idx_init(idx_init), .idx_inc(idx_inc),
      .idx_o(idx), .addr_o(bus_addr)
   );

   opx_byte_buf #(.BYTE_W(BYTE_W), .NBYTES(MAX_BYTES), .HOST_BYTES(HOST_BYTES),
                  .IDX_W(IDX_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .host_ld(host_ld), .host_data(host_data),
      .res_ld(res_ld), .res_data(res_data), .rd_we(rd_we), .idx(idx),
      .rd_byte(bus_din), .sel_byte(bus_dout), .flat_o(op_data)
   );
endmodule

// File: rtl/opx_seq_chk.sv
module opx_seq_chk #(
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rq_o,
   input logic              gt_i,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              busy,
   input logic              op_valid
);
   logic pend_q, own_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         own_q  <= 1'b0;
      end else begin
         if (rq_o && !own_q) pend_q <= 1'b1;
         if (gt_i && pend_q) begin
            own_q  <= 1'b1;
            pend_q <= 1'b0;
         end
         if (rq_o && own_q) own_q <= 1'b0;
      end
   end

   a_r4_strobe_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd || bus_wr) |-> own_q);
   a_r5_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rq_o |=> !rq_o);
   a_r3_addr_step_rd: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && $past(bus_rd)) |-> bus_addr == $past(bus_addr) + 1'b1);
   a_r6_addr_step_wr: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && $past(bus_wr)) |-> bus_addr == $past(bus_addr) + 1'b1);
   a_r6_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(bus_rd || bus_wr || rq_o || op_valid));
   a_r7_valid_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> !busy);
endmodule

bind opx_seq opx_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rq_o(rq_o), .gt_i(gt_i), .bus_rd(bus_rd),
   .bus_wr(bus_wr), .bus_addr(bus_addr), .busy(busy), .op_valid(op_valid)
);

// File: tb/tb_opx_seq.sv
module tb_opx_seq;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        host_cyc = 0, host_wr = 0, result_rdy = 0, gt_i = 0;
   logic [19:0] host_addr = '0;
   logic [15:0] host_data = '0;
   logic [1:0]  len_code = '0;
   logic [79:0] res_data = '0;
   logic        rq_o, bus_rd, bus_wr, busy, op_valid;
   logic [19:0] bus_addr;
   logic [7:0]  bus_din, bus_dout;
   logic [79:0] op_data;

   logic [7:0]  mem [256];
   logic [79:0] exp_q [$];
   int total = 0, bad = 0;
   int req_cnt = 0, rel_cnt = 0, strobe_cnt = 0;
   bit tb_own = 0;
   bit done = 0;

   always #10 clk = ~clk;

   assign bus_din = mem[bus_addr[7:0]];

   opx_seq dut (
      .clk(clk), .rst_n(rst_n), .host_cyc(host_cyc), .host_wr(host_wr),
      .host_addr(host_addr), .host_data(host_data), .len_code(len_code),
      .result_rdy(result_rdy), .res_data(res_data), .gt_i(gt_i), .rq_o(rq_o),
      .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .busy(busy), .op_valid(op_valid),
      .op_data(op_data)
   );

   task automatic chk(input bit ok, input string tag, input logic [79:0] act,
                      input logic [79:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int len_of(input logic [1:0] c);
      case (c)
         2'd0: return 2;
         2'd1: return 4;
         2'd2: return 8;
         default: return 10;
      endcase
   endfunction

   // monitor: memory writes, strobe counting, scoreboard of load results
   initial forever begin
      @(negedge clk);
      if (bus_rd || bus_wr) strobe_cnt++;
      if (bus_wr) mem[bus_addr[7:0]] = bus_dout;
      if (op_valid) begin
         if (exp_q.size() == 0) chk(0, "R7 unexpected op_valid", op_data, '0);
         else begin
            logic [79:0] e;
            e = exp_q.pop_front();
            chk(op_data === e, "R7 operand", op_data, e);
         end
      end
   end

   // host side of the request/grant handshake
   initial forever begin
      @(negedge clk);
      if (rq_o) begin
         if (!tb_own) begin
            int s0;
            req_cnt++;
            s0 = strobe_cnt;
            repeat (2) @(negedge clk);
            chk(strobe_cnt == s0, "R4 strobe before grant", 80'(strobe_cnt), 80'(s0));
            gt_i = 1;
            @(negedge clk);
            gt_i = 0;
            tb_own = 1;
         end else begin
            rel_cnt++;
            tb_own = 0;
         end
      end
   end

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic do_load(input logic [19:0] a, input logic [1:0] c, input bit intrude);
      logic [79:0] e;
      int n, r0, l0, s0;
      n = len_of(c);
      e = '0;
      for (int i = 0; i < n; i++) e[i*8 +: 8] = mem[8'(a[7:0] + i)];
      exp_q.push_back(e);
      r0 = req_cnt; l0 = rel_cnt; s0 = strobe_cnt;
      @(negedge clk);
      host_cyc = 1; host_wr = 0; host_addr = a; len_code = c;
      host_data = {mem[8'(a[7:0] + 1)], mem[a[7:0]]};
      @(negedge clk);
      host_cyc = 0; host_data = '0;
      chk(busy === 1'b1, "R1 busy after cycle", 80'(busy), 80'(1));
      if (n > 2) begin
         while (!bus_rd) @(negedge clk);
         chk(bus_addr === a + 20'd2, "R3 first fetch address", 80'(bus_addr), 80'(a + 20'd2));
         if (intrude) begin
            host_cyc = 1; host_addr = a + 20'h40; len_code = 2'd0;
            @(negedge clk);
            host_cyc = 0;
         end
      end
      wait_idle();
      @(negedge clk);
      chk(exp_q.size() == 0, "R7 operand delivered", 80'(exp_q.size()), 80'(0));
      chk(strobe_cnt - s0 == n - 2, "R3 fetch count", 80'(strobe_cnt - s0), 80'(n - 2));
      chk(req_cnt - r0 == (n > 2 ? 1 : 0), "R2 takeover count", 80'(req_cnt - r0),
          80'(n > 2 ? 1 : 0));
      chk(rel_cnt - l0 == req_cnt - r0, "R5 release per takeover", 80'(rel_cnt - l0),
          80'(req_cnt - r0));
      chk(busy === 1'b0, "R1 idle after load", 80'(busy), 80'(0));
   endtask

   task automatic do_store(input logic [19:0] a, input logic [1:0] c,
                           input logic [79:0] d, input bit intrude);
      int n, r0, l0;
      logic [7:0] sent;
      n = len_of(c);
      sent = mem[8'(a[7:0] + n)];
      r0 = req_cnt; l0 = rel_cnt;
      @(negedge clk);
      host_cyc = 1; host_wr = 1; host_addr = a; len_code = c;
      @(negedge clk);
      host_cyc = 0; host_wr = 0;
      if (intrude) begin
         host_cyc = 1; host_addr = a + 20'h30; len_code = 2'd3;
         @(negedge clk);
         host_cyc = 0;
      end
      repeat (4) @(negedge clk);
      chk(req_cnt == r0, "R6 no request before result", 80'(req_cnt), 80'(r0));
      chk(busy === 1'b1, "R6 busy while waiting", 80'(busy), 80'(1));
      res_data = d; result_rdy = 1;
      @(negedge clk);
      result_rdy = 0; res_data = '0;
      wait_idle();
      @(negedge clk);
      for (int i = 0; i < n; i++)
         chk(mem[8'(a[7:0] + i)] === d[i*8 +: 8], "R6 stored byte",
             80'(mem[8'(a[7:0] + i)]), 80'(d[i*8 +: 8]));
      chk(mem[8'(a[7:0] + n)] === sent, "R6 byte past operand untouched",
          80'(mem[8'(a[7:0] + n)]), 80'(sent));
      chk(req_cnt - r0 == 1, "R6 one takeover", 80'(req_cnt - r0), 80'(1));
      chk(rel_cnt - l0 == 1, "R5 one release", 80'(rel_cnt - l0), 80'(1));
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && rq_o === 1'b0 && bus_rd === 1'b0 && bus_wr === 1'b0
          && op_valid === 1'b0, "R9 reset state", 80'({busy, rq_o, bus_rd, bus_wr, op_valid}), 80'(0));
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(busy === 1'b0, "R9 idle after reset", 80'(busy), 80'(0));

      do_load(20'hA3F10, 2'd0, 0);   // R2 short load
      do_load(20'h51220, 2'd1, 0);   // R3 4 bytes
      do_load(20'h00040, 2'd2, 0);   // R3 8 bytes
      do_load(20'hFFF60, 2'd3, 0);   // R5 10 bytes held
      do_load(20'h12380, 2'd3, 1);   // R8 stray host cycle

      do_store(20'h300A0, 2'd0, 80'h0000_0000_0000_0000_C35A, 0);
      do_store(20'h300B0, 2'd1, 80'h0000_0000_0000_DEAD_BEEF, 0);
      do_store(20'h300C0, 2'd2, 80'h0000_0123_4567_89AB_CDEF, 0);
      do_store(20'h300D0, 2'd3, 80'h9988_7766_5544_3322_1100, 1); // R8 stray cycle

      do_load(20'h300D0, 2'd3, 0);   // R7 read back stored operand

      repeat (5) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule